// File: doc/BRIEF.md
# MIDI System Exclusive Dump Framer

This block turns a stream of sequence-data bytes into a series of MIDI System Exclusive bulk-dump messages and hands them, one byte at a time, to a separate MIDI UART transmitter. A one-cycle start request, together with a 7-bit device number sampled on that request, opens a dump. The block then pulls payload bytes through a valid/ready handshake and emits each message as a six-byte header, a run of payload bytes and an end-of-exclusive byte.

The payload is cut into consecutive blocks. The opening block of a dump holds one byte more than each later block. Every block carries a fresh copy of the header and is closed by its own terminator. The source marks the final payload byte, and the block signals completion with a single-cycle pulse once the closing terminator has been taken by the transmitter. Payload bytes that arrive with the top bit set are sent with that bit cleared and are flagged. The default block sizes are 57 and 56 bytes. The device number in normal use is 12h.

Top module: `sysex_dump_framer`

## Requirements
- R1: While reset is active and in the cycle after it is released, tx_valid_o, pay_ready_o, err_o and done_o are all low.
- R2: Every message is sent as F0h, 42h, 30h, the device byte, 07h, 48h, then its payload bytes in arrival order, then F7h.
- R3: The device byte equals {1'b0, dev_id_i} as sampled in the cycle start_i is accepted, and it is the same in every block of that dump.
- R4: The first block of a dump carries min(FIRST_LEN, remaining) payload bytes and every later block min(NEXT_LEN, remaining). A short final block is still closed with F7h. When the last payload byte exactly fills a block, no empty block follows.
- R5: A payload byte is sent with bit 7 cleared and bits 6..0 unchanged. err_o is high for exactly the cycle in which such a byte that arrived with bit 7 set is first presented on tx_data_o. Only F0h and F7h are ever presented with bit 7 set.
- R6: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o holds its value. A byte is counted as sent on a clock edge with both signals high, and no byte is lost or repeated.
- R7: done_o is a one-cycle pulse in the cycle after the edge on which the final F7h of a dump is accepted. During that pulse tx_valid_o and pay_ready_o are low.
- R8: start_i has no effect while a dump is in progress, including its device number.
- R9: pay_ready_o is high only in the payload phase of a block and only when the output byte slot is empty or is being emptied in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a dump (accepted only when idle) |
| dev_id_i | input | 7 | Device number placed in every header of the dump |
| pay_valid_i | input | 1 | Payload byte available |
| pay_data_i | input | 8 | Payload byte |
| pay_last_i | input | 1 | Marks the final payload byte of the dump |
| pay_ready_o | output | 1 | Payload byte taken on this edge when valid is high |
| tx_valid_o | output | 1 | Byte presented to the transmitter |
| tx_data_o | output | 8 | Byte to transmit |
| tx_ready_i | input | 1 | Transmitter takes the presented byte |
| err_o | output | 1 | Presented payload byte had bit 7 set on arrival |
| done_o | output | 1 | One-cycle pulse after the last terminator is accepted |

## Verification
The closing of a full block and the end of the payload stream can land on the same payload byte. The block must then send one terminator and finish rather than open an empty block. The bench sweeps every dump length from 1 to 10 with block sizes of 3 and 2, so both the coincident case and the case where the stream ends part-way through a block occur. Each is run under an always-ready transmitter, a pseudo-random stalling transmitter and a gappy payload source. The captured byte stream is compared byte for byte with a message list built arithmetically in the bench, and the cycle of the done pulse is compared with the handshake of the last terminator.

// File: rtl/sysex_dump_pkg.sv
package sysex_dump_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_EOX,
        ST_FIN
    } dump_st_e;

    localparam logic [7:0] BYTE_SOX   = 8'hF0;
    localparam logic [7:0] BYTE_EOX   = 8'hF7;
    localparam logic [7:0] BYTE_MAKER = 8'h42;
    localparam logic [7:0] BYTE_FMT   = 8'h30;
    localparam logic [7:0] BYTE_MODEL = 8'h07;
    localparam logic [7:0] BYTE_FUNC  = 8'h48;

    localparam int HDR_LEN   = 6;
    localparam int HDR_IDX_W = 3;

endpackage

// File: rtl/sysex_hdr_rom.sv
module sysex_hdr_rom
    import sysex_dump_pkg::*;
(
    input  logic [HDR_IDX_W-1:0] idx_i,
    input  logic [6:0]           dev_i,
    output logic [7:0]           byte_o
);

    // Position of each byte is fixed by the message layout.
    always_comb begin
        case (idx_i)
            3'd0:    byte_o = BYTE_SOX;
            3'd1:    byte_o = BYTE_MAKER;
            3'd2:    byte_o = BYTE_FMT;
            3'd3:    byte_o = {1'b0, dev_i};
            3'd4:    byte_o = BYTE_MODEL;
            default: byte_o = BYTE_FUNC;
        endcase
    end

endmodule

// File: rtl/sysex_pay_clean.sv
module sysex_pay_clean #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] clean_o,
    output logic         bad_o
);

    assign clean_o = {1'b0, raw_i[W-2:0]};
    assign bad_o   = raw_i[W-1];

endmodule

// File: rtl/sysex_dump_framer.sv
module sysex_dump_framer
    import sysex_dump_pkg::*;
#(
    parameter int FIRST_LEN = 57,
    parameter int NEXT_LEN  = 56
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [6:0] dev_id_i,
    input  logic       pay_valid_i,
    input  logic [7:0] pay_data_i,
    input  logic       pay_last_i,
    output logic       pay_ready_o,
    output logic       tx_valid_o,
    output logic [7:0] tx_data_o,
    input  logic       tx_ready_i,
    output logic       err_o,
    output logic       done_o
);

    localparam int MAX_LEN = (FIRST_LEN > NEXT_LEN) ? FIRST_LEN : NEXT_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(FIRST_LEN);
    localparam logic [CNT_W-1:0] NEXT_C  = CNT_W'(NEXT_LEN);
    localparam logic [HDR_IDX_W-1:0] HDR_END = HDR_IDX_W'(HDR_LEN - 1);

    typedef struct packed {
        dump_st_e             st;
        logic [HDR_IDX_W-1:0] hidx;
        logic [CNT_W-1:0]     cnt;
        logic                 first;
        logic                 fin;
        logic [6:0]           dev;
        logic                 txv;
        logic [7:0]           txd;
        logic                 err;
        logic                 done;
    } frm_state_t;

    frm_state_t s_q, s_d;

    logic [7:0]       hdr_byte;
    logic [7:0]       pay_clean;
    logic             pay_bad;
    logic             slot_free;
    logic             pay_rdy;
    logic [CNT_W-1:0] blk_limit;
    logic [CNT_W-1:0] cnt_inc;

    sysex_hdr_rom u_hdr (
        .idx_i  (s_q.hidx),
        .dev_i  (s_q.dev),
        .byte_o (hdr_byte)
    );

    sysex_pay_clean #(.W(8)) u_clean (
        .raw_i   (pay_data_i),
        .clean_o (pay_clean),
        .bad_o   (pay_bad)
    );

    always_comb begin
        s_d       = s_q;
        s_d.err   = 1'b0;
        s_d.done  = 1'b0;
        slot_free = !s_q.txv || tx_ready_i;
        pay_rdy   = 1'b0;
        blk_limit = s_q.first ? FIRST_C : NEXT_C;
        cnt_inc   = s_q.cnt + CNT_W'(1);

        if (slot_free) begin
            s_d.txv = 1'b0;
        end

        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st    = ST_HDR;
                    s_d.hidx  = '0;
                    s_d.first = 1'b1;
                    s_d.fin   = 1'b0;
                    s_d.dev   = dev_id_i;
                end
            end
            ST_HDR: begin
                if (slot_free) begin
                    s_d.txv = 1'b1;
                    s_d.txd = hdr_byte;
                    if (s_q.hidx == HDR_END) begin
                        s_d.st  = ST_PAY;
                        s_d.cnt = '0;
                    end else begin
                        s_d.hidx = s_q.hidx + HDR_IDX_W'(1);
                    end
                end
            end
            ST_PAY: begin
                pay_rdy = slot_free;
                if (slot_free && pay_valid_i) begin
                    s_d.txv = 1'b1;
                    s_d.txd = pay_clean;
                    s_d.err = pay_bad;
                    s_d.cnt = cnt_inc;
                    s_d.fin = pay_last_i;
                    if (pay_last_i || (cnt_inc == blk_limit)) begin
                        s_d.st = ST_EOX;
                    end
                end
            end
            ST_EOX: begin
                if (slot_free) begin
                    s_d.txv   = 1'b1;
                    s_d.txd   = BYTE_EOX;
                    s_d.hidx  = '0;
                    s_d.first = 1'b0;
                    s_d.st    = s_q.fin ? ST_FIN : ST_HDR;
                end
            end
            ST_FIN: begin
                if (slot_free) begin
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign pay_ready_o = pay_rdy;
    assign tx_valid_o  = s_q.txv;
    assign tx_data_o   = s_q.txd;
    assign err_o       = s_q.err;
    assign done_o      = s_q.done;

endmodule

// File: rtl/sysex_dump_framer_chk.sv
module sysex_dump_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid_o,
    input logic       tx_ready_i,
    input logic [7:0] tx_data_o,
    input logic       pay_ready_o,
    input logic       err_o,
    input logic       done_o
);

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R6

    AST_TOP_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_data_o[7]) |-> (tx_data_o == 8'hF0 || tx_data_o == 8'hF7)); // R5

    AST_ERR_ON_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (tx_valid_o && !tx_data_o[7])); // R5

    AST_DONE_AFTER_EOX: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(tx_valid_o && tx_ready_i && tx_data_o == 8'hF7)); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!tx_valid_o && !pay_ready_o)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_NO_PAY_IN_SOX: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i && tx_data_o == 8'hF0) |-> !pay_ready_o); // R9

endmodule

bind sysex_dump_framer sysex_dump_framer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i),
    .tx_data_o   (tx_data_o),
    .pay_ready_o (pay_ready_o),
    .err_o       (err_o),
    .done_o      (done_o)
);

// File: tb/tb_sysex_dump_framer.sv
`timescale 1ns/1ps
module tb_sysex_dump_framer;

    localparam int FL = 3;
    localparam int NL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [6:0] dev_id_i = '0;
    logic       pay_valid_i = 1'b0;
    logic [7:0] pay_data_i = '0;
    logic       pay_last_i = 1'b0;
    logic       pay_ready_o;
    logic       tx_valid_o;
    logic [7:0] tx_data_o;
    logic       tx_ready_i = 1'b0;
    logic       err_o;
    logic       done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int exp_b [0:127];
    int exp_r [0:127];
    int exp_n;
    int got_b [0:127];
    int got_n;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    sysex_dump_framer #(.FIRST_LEN(FL), .NEXT_LEN(NL)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dev_id_i(dev_id_i),
        .pay_valid_i(pay_valid_i), .pay_data_i(pay_data_i), .pay_last_i(pay_last_i),
        .pay_ready_o(pay_ready_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
        .tx_ready_i(tx_ready_i), .err_o(err_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int pat(input int k, input int n);
        return (k * 53 + n * 11 + 129) & 255;
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // Expected message list: header, payload slice, terminator per block (R2, R3, R4).
    task automatic build(input int n, input logic [6:0] dev);
        int rem, k, take;
        bit first;
        exp_n = 0; rem = n; k = 0; first = 1;
        while (rem > 0) begin
            exp_b[exp_n] = 8'hF0; exp_r[exp_n] = 2; exp_n++;
            exp_b[exp_n] = 8'h42; exp_r[exp_n] = 2; exp_n++;
            exp_b[exp_n] = 8'h30; exp_r[exp_n] = 2; exp_n++;
            exp_b[exp_n] = {1'b0, dev}; exp_r[exp_n] = 3; exp_n++;
            exp_b[exp_n] = 8'h07; exp_r[exp_n] = 2; exp_n++;
            exp_b[exp_n] = 8'h48; exp_r[exp_n] = 2; exp_n++;
            take = first ? FL : NL;
            if (take > rem) take = rem;
            for (int j = 0; j < take; j++) begin
                exp_b[exp_n] = pat(k, n) & 8'h7F; exp_r[exp_n] = 5; exp_n++;
                k++;
            end
            rem -= take;
            exp_b[exp_n] = 8'hF7; exp_r[exp_n] = 4; exp_n++;
            first = 0;
        end
    endtask

    task automatic run_dump(input int n, input int mode, input logic [6:0] dev);
        int p, it, last_fire, done_it, done_cnt, err_cnt, exp_err, prev_d;
        bit prev_stall, stop;
        build(n, dev);
        exp_err = 0;
        for (int k = 0; k < n; k++) if (pat(k, n) >= 128) exp_err++;
        got_n = 0; p = 0; it = 0; last_fire = -10; done_it = -10;
        done_cnt = 0; err_cnt = 0; prev_stall = 0; prev_d = 0; stop = 0;
        while (!stop) begin
            @(negedge clk);
            if (it > 0) begin
                // outputs from the edge just passed
                if (err_o) err_cnt++;
                if (done_o) begin
                    done_cnt++; done_it = it;
                    check(!tx_valid_o && !pay_ready_o, "R7 quiet at done", tx_valid_o, 0);
                end
                if (prev_stall)
                    check(tx_valid_o && tx_data_o == prev_d[7:0], "R6 hold under stall", tx_data_o, prev_d);
            end else begin
                check(!pay_ready_o && !tx_valid_o, "R9 idle before start", pay_ready_o, 0);
            end
            step_lfsr();
            // R8: second start with another device number mid-dump
            start_i  = (it == 0) || (it == 7);
            dev_id_i = (it == 7) ? ~dev : dev;
            case (mode)
                0: tx_ready_i = 1'b1;
                1: tx_ready_i = lfsr[0] | lfsr[3];
                default: tx_ready_i = lfsr[1] & lfsr[5];
            endcase
            pay_valid_i = (p < n) && ((mode != 2) || lfsr[7] || lfsr[9]);
            pay_data_i  = 8'(pat(p, n));
            pay_last_i  = (p == n - 1);
            #1;
            if (tx_valid_o && tx_ready_i) begin
                if (got_n < 128) got_b[got_n] = tx_data_o;
                got_n++;
                last_fire = it;
            end
            prev_stall = tx_valid_o && !tx_ready_i;
            prev_d = tx_data_o;
            if (pay_valid_i && pay_ready_o) p++;
            it++;
            if ((done_it > 0 && it > done_it + 4) || it > 3000) stop = 1;
        end
        start_i = 1'b0; pay_valid_i = 1'b0;
        check(got_n == exp_n, "R4 byte count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            check(got_b[i] == exp_b[i], $sformatf("R%0d byte %0d n=%0d", exp_r[i], i, n), got_b[i], exp_b[i]);
        check(p == n, "R6 payload consumed once each", p, n);
        check(err_cnt == exp_err, "R5 error pulses", err_cnt, exp_err);
        check(done_cnt == 1, "R7 done count", done_cnt, 1);
        check(done_it == last_fire + 1, "R7 done timing", done_it, last_fire + 1);
        check(!pay_ready_o && !tx_valid_o, "R9 idle after done", pay_ready_o, 0);
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(!tx_valid_o && !pay_ready_o && !err_o && !done_o, "R1 in reset", tx_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tx_valid_o && !pay_ready_o && !err_o && !done_o, "R1 after reset", tx_valid_o, 0);
        for (int mode = 0; mode < 3; mode++)
            for (int n = 1; n <= 10; n++)
                run_dump(n, mode, (mode == 0) ? 7'h12 : 7'(n * 7 + mode));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule